// File: doc/BRIEF.md
# Bit-Manipulation Instruction Execution Unit

This block is a small multi-cycle execution unit for an 8-bit accumulator machine. It runs only a bit-oriented instruction subset. The subset covers setting or clearing a single bit, branching on the state of a single bit, swapping the two nibbles of a zero-page byte, storing an immediate byte to zero page, an unconditional relative branch, and setting or clearing a T flag. Every cycle the unit makes exactly one access on a byte-wide synchronous memory port with a 16-bit address. Any access is held while the memory deasserts its ready input.

The bit number and the polarity of an operation come straight from opcode fields. Most operations exist in two forms, one on the accumulator and one on a zero-page byte, and each form has its own fixed bus-cycle sequence, dummy reads included. The program counter, the accumulator and the T flag are brought out for observation. An opcode outside the subset produces a one-cycle illegal pulse and is skipped.

Top module: `bitop_unit`

## Requirements
- R1: While reset is low, the program counter equals RESET_PC (default 0x0200), the accumulator is 0x00, T is 0, the illegal pulse is low and no write is driven.
- R2: Every cycle carries exactly one access, either a read or a write. An access completes only in a cycle with ready high. While ready is low, the address, the strobes, PC, A and T keep their values.
- R3: Opcode bits [7:5] give the bit index and opcode bit 4 gives the sense: 0 means set, or branch if the bit is set; 1 means clear, or branch if the bit is clear. Low nibble 0xB acts on A. After the opcode fetch it makes one dummy read at PC without incrementing PC, and then updates A.
- R4: Low nibble 0xF acts on a zero-page byte in this order: fetch the address byte, read that location, then write the byte with the selected bit set or cleared back to the same location.
- R5: Low nibble 0x3 is a branch on a bit of A. It fetches a signed offset, then makes a dummy read at the incremented PC. If the condition holds, PC becomes (PC after the offset fetch + sign-extended offset) mod 2^16.
- R6: Low nibble 0x7 is a branch on a bit of a zero-page byte. It fetches the address byte, reads the location, fetches the offset and makes a dummy read at PC. The target rule is the same as in R5.
- R7: Opcode 0x3C fetches a data byte, then a zero-page address byte, and writes the data byte to that address.
- R8: Opcode 0x82 fetches a zero-page address, reads the byte there and writes it back with its two nibbles swapped.
- R9: Opcode 0x80 always branches. It fetches the offset and makes a dummy read at PC. If the target is in a different 256-byte page, it makes one more read at {old PC high byte, target low byte} before PC takes the target.
- R10: Opcode 0x32 sets T and opcode 0x12 clears T. Each makes one dummy read at PC without incrementing it.
- R11: Any other opcode raises the illegal output for exactly one cycle, right after its fetch, and the next opcode fetch follows at the incremented PC.
- R12: Writes go only to zero page (address high byte 0x00), and after a program the zero-page bytes hold the values the instructions above define.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| memAddr | output | 16 | Address of the current access |
| memRd | output | 1 | Current access is a read |
| memWr | output | 1 | Current access is a write |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid in the cycle the read completes |
| memReady | input | 1 | Current access completes at the next edge |
| pcOut | output | 16 | Program counter |
| accOut | output | 8 | Accumulator |
| tFlag | output | 1 | T flag (status bit 5) |
| illegal | output | 1 | One-cycle pulse for an unimplemented opcode |

## Verification
The bound assertions check four things on every cycle. There is exactly one access per cycle. A stalled access keeps its address, strobes and architectural state. Writes stay inside zero page. A and T change only after a completed read at the dummy-read address, and an illegal pulse only ever follows a completed read. The exact order of bus cycles for each form, the taken and not-taken branch targets, the extra page-crossing read, the nibble swap and the zero-page results can only be shown by the bench's scenarios. The bench runs one program, first with ready held high and then with stalls inserted, and compares every completed access against a trace it computes itself.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam logic [7:0] OP_LDM   = 8'h3C;
  localparam logic [7:0] OP_SWAP  = 8'h82;
  localparam logic [7:0] OP_BRA   = 8'h80;
  localparam logic [7:0] OP_SET_T = 8'h32;
  localparam logic [7:0] OP_CLR_T = 8'h12;

  localparam logic [3:0] NIB_BR_ACC  = 4'h3;
  localparam logic [3:0] NIB_BR_ZP   = 4'h7;
  localparam logic [3:0] NIB_MOD_ACC = 4'hB;
  localparam logic [3:0] NIB_MOD_ZP  = 4'hF;

  typedef enum logic [3:0] {
    ST_FETCH, ST_ACC_DUMMY, ST_T_DUMMY, ST_IMM, ST_ZP_ADDR,
    ST_ZP_READ, ST_ZP_WRITE, ST_OFFSET, ST_BR_DUMMY, ST_PAGE_DUMMY
  } state_t;

  typedef enum logic [1:0] {ADDR_PC, ADDR_ZP, ADDR_PAGE} addrSel_t;
  typedef enum logic [1:0] {TMP_HOLD, TMP_RAW, TMP_BITOP, TMP_SWAP} tmpSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    logic     rd;
    logic     wr;
    logic     incPc;
    logic     ldOpcode;
    logic     ldZp;
    logic     ldOffset;
    tmpSel_t  tmpSel;
    logic     accBitop;
    logic     tWrite;
    logic     takeBranch;
  } strobes_t;

  // First state after an opcode fetch; ST_FETCH marks an unimplemented opcode.
  function automatic state_t firstState(input logic [7:0] op);
    state_t s;
    s = ST_FETCH;
    unique case (op[3:0])
      NIB_BR_ACC:  s = ST_OFFSET;
      NIB_BR_ZP:   s = ST_ZP_ADDR;
      NIB_MOD_ACC: s = ST_ACC_DUMMY;
      NIB_MOD_ZP:  s = ST_ZP_ADDR;
      default: begin
        if (op == OP_LDM)                           s = ST_IMM;
        else if (op == OP_SWAP)                     s = ST_ZP_ADDR;
        else if (op == OP_BRA)                      s = ST_OFFSET;
        else if (op == OP_SET_T || op == OP_CLR_T)  s = ST_T_DUMMY;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       memReady,
  input  logic [7:0] memRdata,
  input  logic [7:0] opcode,
  input  logic       branchCond,
  input  logic       pageCross,
  output strobes_t   strobes,
  output logic       illegal
);

  state_t state, nextState;
  strobes_t st;

  always_comb begin
    st = '0;
    st.addrSel = ADDR_PC;
    st.tmpSel  = TMP_HOLD;
    nextState  = state;
    unique case (state)
      ST_FETCH: begin
        st.rd = 1'b1; st.incPc = 1'b1; st.ldOpcode = 1'b1;
        nextState = firstState(memRdata);
      end
      ST_ACC_DUMMY: begin
        st.rd = 1'b1; st.accBitop = 1'b1;
        nextState = ST_FETCH;
      end
      ST_T_DUMMY: begin
        st.rd = 1'b1; st.tWrite = 1'b1;
        nextState = ST_FETCH;
      end
      ST_IMM: begin
        st.rd = 1'b1; st.incPc = 1'b1; st.tmpSel = TMP_RAW;
        nextState = ST_ZP_ADDR;
      end
      ST_ZP_ADDR: begin
        st.rd = 1'b1; st.incPc = 1'b1; st.ldZp = 1'b1;
        nextState = (opcode == OP_LDM) ? ST_ZP_WRITE : ST_ZP_READ;
      end
      ST_ZP_READ: begin
        st.rd = 1'b1; st.addrSel = ADDR_ZP;
        if (opcode == OP_SWAP)               st.tmpSel = TMP_SWAP;
        else if (opcode[3:0] == NIB_BR_ZP)   st.tmpSel = TMP_RAW;
        else                                 st.tmpSel = TMP_BITOP;
        nextState = (opcode[3:0] == NIB_BR_ZP) ? ST_OFFSET : ST_ZP_WRITE;
      end
      ST_ZP_WRITE: begin
        st.wr = 1'b1; st.addrSel = ADDR_ZP;
        nextState = ST_FETCH;
      end
      ST_OFFSET: begin
        st.rd = 1'b1; st.incPc = 1'b1; st.ldOffset = 1'b1;
        nextState = ST_BR_DUMMY;
      end
      ST_BR_DUMMY: begin
        st.rd = 1'b1;
        nextState = ST_FETCH;
        if (opcode == OP_BRA) begin
          if (pageCross) nextState = ST_PAGE_DUMMY;
          else           st.takeBranch = 1'b1;
        end else begin
          st.takeBranch = branchCond;
        end
      end
      ST_PAGE_DUMMY: begin
        st.rd = 1'b1; st.addrSel = ADDR_PAGE; st.takeBranch = 1'b1;
        nextState = ST_FETCH;
      end
      default: nextState = ST_FETCH;
    endcase
  end

  assign strobes = st;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FETCH;
      illegal <= 1'b0;
    end else begin
      if (memReady) state <= nextState;
      illegal <= memReady && (state == ST_FETCH) && (firstState(memRdata) == ST_FETCH);
    end
  end

endmodule

// File: rtl/bitop_dpath.sv
module bitop_dpath
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              memReady,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [7:0]        memWdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [7:0]        accOut,
  output logic              tFlag,
  output logic [7:0]        opcode,
  output logic              branchCond,
  output logic              pageCross
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] PC_STEP = 1;

  logic [ADDR_W-1:0] pcQ, target, offExt;
  logic [7:0] accQ, opQ, zpQ, offQ, tmpQ, branchSrc, bitMask;
  logic tQ;
  logic [IDX_W-1:0] bitIdx;
  logic clrSense;

  assign bitIdx   = opQ[7:5];
  assign clrSense = opQ[4];
  assign bitMask  = 8'b1 << bitIdx;

  function automatic logic [7:0] applyBit(input logic [7:0] v, input logic [7:0] m,
                                          input logic clr);
    return clr ? (v & ~m) : (v | m);
  endfunction

  assign offExt    = {{HI_W{offQ[7]}}, offQ};
  assign target    = pcQ + offExt;
  assign pageCross = target[ADDR_W-1:DATA_W] != pcQ[ADDR_W-1:DATA_W];
  assign branchSrc = (opQ[3:0] == NIB_BR_ACC) ? accQ : tmpQ;
  assign branchCond = branchSrc[bitIdx] != clrSense;

  always_comb begin
    unique case (strobes.addrSel)
      ADDR_ZP:   memAddr = {{HI_W{1'b0}}, zpQ};
      ADDR_PAGE: memAddr = {pcQ[ADDR_W-1:DATA_W], target[DATA_W-1:0]};
      default:   memAddr = pcQ;
    endcase
  end

  assign memRd    = strobes.rd;
  assign memWr    = strobes.wr;
  assign memWdata = tmpQ;
  assign pcOut    = pcQ;
  assign accOut   = accQ;
  assign tFlag    = tQ;
  assign opcode   = opQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= RESET_PC; accQ <= '0; tQ <= 1'b0;
      opQ <= '0; zpQ <= '0; offQ <= '0; tmpQ <= '0;
    end else if (memReady) begin
      if (strobes.takeBranch)  pcQ <= target;
      else if (strobes.incPc)  pcQ <= pcQ + PC_STEP;
      if (strobes.ldOpcode)    opQ <= memRdata;
      if (strobes.ldZp)        zpQ <= memRdata;
      if (strobes.ldOffset)    offQ <= memRdata;
      unique case (strobes.tmpSel)
        TMP_RAW:   tmpQ <= memRdata;
        TMP_BITOP: tmpQ <= applyBit(memRdata, bitMask, clrSense);
        TMP_SWAP:  tmpQ <= {memRdata[3:0], memRdata[7:4]};
        default:   tmpQ <= tmpQ;
      endcase
      if (strobes.accBitop)    accQ <= applyBit(accQ, bitMask, clrSense);
      if (strobes.tWrite)      tQ <= opQ[5];
    end
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memReady,
  output logic [ADDR_W-1:0] pcOut,
  output logic [7:0]        accOut,
  output logic              tFlag,
  output logic              illegal
);

  strobes_t strobes;
  logic [7:0] opcode;
  logic branchCond, pageCross;

  bitop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .memReady(memReady), .memRdata(memRdata),
    .opcode(opcode), .branchCond(branchCond), .pageCross(pageCross),
    .strobes(strobes), .illegal(illegal)
  );

  bitop_dpath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memReady(memReady),
    .memRdata(memRdata), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .pcOut(pcOut), .accOut(accOut), .tFlag(tFlag),
    .opcode(opcode), .branchCond(branchCond), .pageCross(pageCross)
  );

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic              memReady,
  input logic [ADDR_W-1:0] pcOut,
  input logic [7:0]        accOut,
  input logic              tFlag,
  input logic              illegal
);

  assert_one_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memRd, memWr}) == 1);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memReady |=> $stable(memAddr) && $stable(memRd) && $stable(memWr) &&
                  $stable(pcOut) && $stable(accOut) && $stable(tFlag));

  assert_acc_after_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(accOut) |-> $past(memRd && memReady));

  assert_t_dummy_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tFlag) |-> $past(memRd && memReady && (memAddr == pcOut)));

  assert_illegal_after_fetch_R11: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $past(memRd && memReady));

  assert_zero_page_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> memAddr[ADDR_W-1:8] == '0);

endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
  .memReady(memReady), .pcOut(pcOut), .accOut(accOut), .tFlag(tFlag),
  .illegal(illegal)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb;

  typedef struct packed {
    logic        isWr;
    logic        isFetch;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  expA;
    logic        expT;
    logic [3:0]  req;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] memAddr, pcOut;
  logic memRd, memWr, tFlag, illegal;
  logic [7:0] memWdata, accOut;
  logic [7:0] memRdata = 8'h00;
  logic memReady = 1'b1;

  always #5 clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .pcOut(pcOut), .accOut(accOut), .tFlag(tFlag), .illegal(illegal)
  );

  logic [7:0] mem [int];
  int memEpoch = 0;
  item_t expQ[$];
  int checks = 0, failures = 0;
  bit running = 0, done = 0, stallMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int seenIll = 0, expIll = 0, stallCnt = 0;

  logic [15:0] mPc;
  logic [7:0]  mA;
  logic        mT;
  logic [7:0]  mZp [256];

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input logic [3:0] r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", reqName(r), what, act, exp);
    end
  endtask

  // memory model: combinational read, write at the completing edge
  always @(memAddr or memEpoch)
    memRdata = mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'h00;

  always @(posedge clk) begin
    if (rstN && memWr && memReady) begin
      mem[int'(memAddr)] = memWdata;
      memEpoch++;
    end
  end

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady = stallMode ? (lfsr[0] | lfsr[1]) : 1'b1;
  end

  // monitor: pops one expected access per completed access
  always @(negedge clk) begin
    if (running && rstN && !done) begin
      if (illegal) seenIll++;
      if (!memReady) stallCnt++;
      if (memReady && (memRd || memWr)) begin
        if (expQ.size() == 0) begin
          done = 1;
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk((memWr == it.isWr) && (memAddr == it.addr) && (!it.isWr || memWdata == it.data),
              it.req, "access {wr,addr,wdata}", {7'd0, memWr, memAddr, memWdata},
              {7'd0, it.isWr, it.addr, it.data});
          if (it.isFetch)
            chk(pcOut == it.addr && accOut == it.expA && tFlag == it.expT, it.req,
                "state at fetch {pc,a,t}", {7'd0, tFlag, pcOut, accOut},
                {7'd0, it.expT, it.addr, it.expA});
          if (expQ.size() == 0) done = 1;
        end
      end
    end
  end

  // ---------------- driver: program builder and reference model ----------------
  task automatic push(input bit w, input bit f, input logic [15:0] a,
                      input logic [7:0] d, input logic [3:0] r);
    item_t it;
    it.isWr = w; it.isFetch = f; it.addr = a; it.data = d;
    it.expA = mA; it.expT = mT; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic putByte(input logic [7:0] b);
    mem[int'(mPc)] = b;
    mPc = mPc + 16'd1;
  endtask

  task automatic fetchOp(input logic [7:0] op, input logic [3:0] r);
    push(0, 1, mPc, 8'h00, r);
    putByte(op);
  endtask

  task automatic readOperand(input logic [7:0] b, input logic [3:0] r);
    push(0, 0, mPc, 8'h00, r);
    putByte(b);
  endtask

  function automatic logic [7:0] modBit(input logic [7:0] v, input int b, input bit clr);
    return clr ? (v & ~(8'h01 << b)) : (v | (8'h01 << b));
  endfunction

  function automatic logic [15:0] sext(input logic [7:0] o);
    return {{8{o[7]}}, o};
  endfunction

  task automatic emitAccBit(input int b, input bit clr);      // R3
    fetchOp({b[2:0], clr, 4'hB}, 4'd3);
    push(0, 0, mPc, 8'h00, 4'd3);
    mA = modBit(mA, b, clr);
  endtask

  task automatic emitZpBit(input int b, input bit clr, input logic [7:0] zp);  // R4
    logic [7:0] v;
    fetchOp({b[2:0], clr, 4'hF}, 4'd4);
    readOperand(zp, 4'd4);
    push(0, 0, {8'h00, zp}, 8'h00, 4'd4);
    v = modBit(mZp[zp], b, clr);
    push(1, 0, {8'h00, zp}, v, 4'd4);
    mZp[zp] = v;
  endtask

  task automatic emitLdm(input logic [7:0] d, input logic [7:0] zp);   // R7
    fetchOp(8'h3C, 4'd7);
    readOperand(d, 4'd7);
    readOperand(zp, 4'd7);
    push(1, 0, {8'h00, zp}, d, 4'd7);
    mZp[zp] = d;
  endtask

  task automatic emitSwap(input logic [7:0] zp);    // R8
    logic [7:0] v;
    fetchOp(8'h82, 4'd8);
    readOperand(zp, 4'd8);
    push(0, 0, {8'h00, zp}, 8'h00, 4'd8);
    v = {mZp[zp][3:0], mZp[zp][7:4]};
    push(1, 0, {8'h00, zp}, v, 4'd8);
    mZp[zp] = v;
  endtask

  task automatic emitT(input bit setIt);            // R10
    fetchOp(setIt ? 8'h32 : 8'h12, 4'd10);
    push(0, 0, mPc, 8'h00, 4'd10);
    mT = setIt;
  endtask

  task automatic emitIllegal(input logic [7:0] op); // R11
    fetchOp(op, 4'd11);
    expIll++;
  endtask

  task automatic emitBrAcc(input int b, input bit clr, input logic [7:0] off);  // R5
    bit taken;
    fetchOp({b[2:0], clr, 4'h3}, 4'd5);
    readOperand(off, 4'd5);
    push(0, 0, mPc, 8'h00, 4'd5);
    taken = (mA[b] == !clr);
    if (taken) mPc = mPc + sext(off);
  endtask

  task automatic emitBrZp(input int b, input bit clr, input logic [7:0] zp,
                          input logic [7:0] off);       // R6
    bit taken;
    fetchOp({b[2:0], clr, 4'h7}, 4'd6);
    readOperand(zp, 4'd6);
    push(0, 0, {8'h00, zp}, 8'h00, 4'd6);
    readOperand(off, 4'd6);
    push(0, 0, mPc, 8'h00, 4'd6);
    taken = (mZp[zp][b] == !clr);
    if (taken) mPc = mPc + sext(off);
  endtask

  task automatic emitBra(input logic [7:0] off);    // R9
    logic [15:0] tgt;
    fetchOp(8'h80, 4'd9);
    readOperand(off, 4'd9);
    push(0, 0, mPc, 8'h00, 4'd9);
    tgt = mPc + sext(off);
    if (tgt[15:8] != mPc[15:8]) push(0, 0, {mPc[15:8], tgt[7:0]}, 8'h00, 4'd9);
    mPc = tgt;
  endtask

  task automatic buildProgram();
    mPc = 16'h0200; mA = 8'h00; mT = 1'b0;
    for (int i = 0; i < 256; i++) mZp[i] = 8'h00;
    mZp[8'h40] = 8'h5A; mZp[8'h41] = 8'hFF; mZp[8'h42] = 8'h00;
    mem[32'h40] = 8'h5A; mem[32'h41] = 8'hFF; mem[32'h42] = 8'h00;
    emitAccBit(3, 0); emitAccBit(7, 0); emitAccBit(3, 1);        // A -> 0x80
    emitZpBit(0, 0, 8'h40); emitZpBit(6, 1, 8'h41);
    emitLdm(8'hC3, 8'h42); emitSwap(8'h42);
    emitT(1); emitT(0); emitT(1);
    emitIllegal(8'h00); emitIllegal(8'h42);
    emitBrAcc(7, 0, 8'h02);   // taken
    emitBrAcc(7, 1, 8'h10);   // not taken
    emitBrAcc(0, 1, 8'h01);   // taken (bit clear)
    emitBrZp(0, 0, 8'h40, 8'h01);  // taken
    emitBrZp(2, 1, 8'h40, 8'h03);  // taken
    emitBrZp(0, 1, 8'h40, 8'h05);  // not taken
    emitBra(8'h7F);           // same page
    emitBra(8'h7F);           // crosses forward
    emitBra(8'h80);           // crosses backward
    emitAccBit(0, 0);
    emitBra(8'hFE);           // self loop, end of trace
  endtask

  task automatic runOnce(input bit stalls);
    int guard;
    int failBefore;
    failBefore = failures;
    rstN = 1'b0; running = 0; done = 0;
    stallMode = stalls; seenIll = 0; expIll = 0; stallCnt = 0;
    mem.delete(); expQ.delete();
    buildProgram();
    memEpoch++;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pcOut == 16'h0200 && accOut == 8'h00 && tFlag == 1'b0 && !illegal && !memWr,
        4'd1, "reset {pc,a,t,ill,wr}", {pcOut, accOut, 5'd0, tFlag, illegal, memWr},
        {16'h0200, 8'h00, 5'd0, 3'b000});
    running = 1;
    @(posedge clk); #1 rstN = 1'b1;
    guard = 0;
    while (!done && guard < 5000) begin
      @(posedge clk);
      guard++;
    end
    chk(done, 4'd2, "watchdog: trace completed", {31'd0, done}, 32'd1);
    running = 0;
    chk(seenIll == expIll, 4'd11, "illegal pulse cycles", seenIll, expIll);
    for (int z = 8'h40; z <= 8'h42; z++)
      chk(mem[z] == mZp[z], 4'd12, "zero-page byte", {24'd0, mem[z]}, {24'd0, mZp[z]});
    if (stalls)
      chk(stallCnt > 0 && failures == failBefore, 4'd2,
          "stalled run matches trace", stallCnt, 32'd1);
  endtask

  initial begin
    runOnce(0);
    runOnce(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule